// File: doc/BRIEF.md
# Virtually indexed, physically tagged set-associative cache lookup

This block is the lookup path of a set-associative cache. It picks the set from untranslated address bits, so the set read begins in the same cycle the address is offered, while address translation is still in progress. One cycle later the translated physical page number arrives. It is compared against the tags that were read from every way of the selected set. The block then returns a registered hit flag, the matching way and one data word of the line.

Some of the set-index bits lie above the page offset. They are therefore virtual page-number bits, and this group of bits is the page colour. Two virtual aliases of one physical page land in the same set only when they share a colour. The block reports the colour of each lookup. It also flags any lookup whose virtual colour differs from the physical bits at the same positions, so that a colouring policy can be checked.

A separate fill port writes a whole line at once. Within the set it picks an invalid way first and otherwise a per-set round-robin victim. At full size the cache is 1 MB with 16 ways and 64-byte lines, which gives 1024 sets. With 8 KB pages that needs 3 colour bits, or 8 colours. The defaults are a reduced configuration for simulation: 16 sets, 4 ways, 64-byte lines, 256-byte pages, 32-bit words, a 24-bit physical page number and 2 colour bits.

Top module: `vipt_cache`

## Requirements
- R1: An active-low asynchronous reset invalidates every line and clears all round-robin pointers to way 0. The first cycle after reset shows rsp_valid low, and any lookup made after reset misses.
- R2: The set index is VA[9:6], carried as req_vword[7:4]. A lookup hits when a valid way of that set holds a tag equal to xlat_ppn, which is PA[31:8].
- R3: A request sampled with req_valid at clock edge k uses the xlat_ppn sampled at edge k+1. The response is registered at edge k+1. rsp_valid is high for exactly that one cycle per request.
- R4: On a hit, rsp_data is 32-bit word i of the line, where i = VA[5:2] (req_vword[3:0]) and word i occupies line bits [32*i+31 : 32*i]. On a miss, rsp_hit, rsp_way and rsp_data are all zero.
- R5: A fill writes fill_line and the tag fill_ppn into set fill_set. The way it uses is the lowest-numbered invalid way of that set, if one exists.
- R6: When every way of the set is valid, a fill replaces the way named by that set's round-robin pointer. The pointer then advances by one modulo the way count. Each set keeps its own pointer.
- R7: rsp_colour equals VA[9:8] (req_vword[7:6]) of the request. rsp_alias is high when that colour differs from PA[9:8] (xlat_ppn[1:0]).
- R8: At most one way matches in any lookup.
- R9: Two virtual addresses with the same set index and colour but different upper bits, translating to one physical page, hit the same way and return the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request |
| req_vword | input | 8 | VA[9:2]: set index, colour and word select |
| xlat_ppn | input | 24 | Translated PA[31:8], valid the cycle after the request |
| fill_valid | input | 1 | Write one line |
| fill_set | input | 4 | Set written by the fill |
| fill_ppn | input | 24 | Physical tag of the filled line |
| fill_line | input | 512 | Whole line of data |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 2 | Way that hit |
| rsp_data | output | 32 | Selected data word |
| rsp_colour | output | 2 | Page colour of the request |
| rsp_alias | output | 1 | Virtual colour differs from physical colour |

## Verification
On every cycle the assertions check four things: the two-edge request-to-response spacing, the single-match rule across ways, zeroed outputs on a miss, and the alias flag against the physical colour bits that were presented. Other behaviour depends on the history of fills, so only the bench scenarios can show it. That covers the lowest-invalid-way choice, round-robin victims kept independently per set, eviction of an old tag, synonym hits from different virtual page numbers, and word selection within a line. The bench compares all of these against a reference model of the tag and data arrays.

// File: rtl/vipt_cache_pkg.sv
package vipt_cache_pkg;

    // Index of the lowest zero bit; returns 64 when none is clear.
    function automatic int lowest_clear(input logic [63:0] vec);
        int idx;
        idx = 64;
        for (int i = 63; i >= 0; i--) begin
            if (!vec[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/vipt_way_bank.sv
module vipt_way_bank #(
    parameter int SET_W     = 4,
    parameter int TAG_W     = 24,
    parameter int LINE_BITS = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SET_W-1:0]     wr_set,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic [LINE_BITS-1:0] wr_line,
    input  logic                 rd_en,
    input  logic [SET_W-1:0]     rd_set,
    output logic                 rd_valid,
    output logic [TAG_W-1:0]     rd_tag,
    output logic [LINE_BITS-1:0] rd_line,
    input  logic [SET_W-1:0]     probe_set,
    output logic                 probe_valid
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0]      valid_q;
    logic [TAG_W-1:0]     tag_q  [SETS];
    logic [LINE_BITS-1:0] line_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_set] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set]  <= wr_tag;
            line_q[wr_set] <= wr_line;
        end
    end

    // Set read launched in the request cycle, result held for the compare stage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_tag   <= '0;
            rd_line  <= '0;
        end else if (rd_en) begin
            rd_valid <= valid_q[rd_set];
            rd_tag   <= tag_q[rd_set];
            rd_line  <= line_q[rd_set];
        end
    end

    assign probe_valid = valid_q[probe_set];

endmodule

// File: rtl/vipt_victim.sv
module vipt_victim #(
    parameter int WAYS  = 4,
    parameter int SET_W = 4,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAYS-1:0]  set_valid,
    output logic [WAYS-1:0]  victim_oh
);
    localparam int SETS = 1 << SET_W;

    logic [WAY_W-1:0] rr_q [SETS];
    logic [WAY_W-1:0] pick;
    logic             full;

    always_comb begin
        full = &set_valid;
        pick = rr_q[fill_set];
        if (!full) pick = WAY_W'(vipt_cache_pkg::lowest_clear(64'(set_valid)));
        victim_oh = WAYS'(1) << pick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (fill_en && full) begin
            rr_q[fill_set] <= (rr_q[fill_set] == WAY_W'(WAYS - 1)) ? '0 : rr_q[fill_set] + 1'b1;
        end
    end

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
    parameter int PA_W       = 32,
    parameter int PAGE_OFF_W = 8,
    parameter int LINE_OFF_W = 6,
    parameter int SET_W      = 4,
    parameter int WAYS       = 4,
    parameter int WORD_W     = 32,
    localparam int TAG_W     = PA_W - PAGE_OFF_W,
    localparam int LINE_BITS = 8 << LINE_OFF_W,
    localparam int BYTE_W    = $clog2(WORD_W / 8),
    localparam int VWORD_W   = LINE_OFF_W + SET_W - BYTE_W,
    localparam int COLOUR_W  = LINE_OFF_W + SET_W - PAGE_OFF_W,
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [VWORD_W-1:0]   req_vword,
    input  logic [TAG_W-1:0]     xlat_ppn,
    input  logic                 fill_valid,
    input  logic [SET_W-1:0]     fill_set,
    input  logic [TAG_W-1:0]     fill_ppn,
    input  logic [LINE_BITS-1:0] fill_line,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [WAY_W-1:0]     rsp_way,
    output logic [WORD_W-1:0]    rsp_data,
    output logic [COLOUR_W-1:0]  rsp_colour,
    output logic                 rsp_alias
);
    localparam int WSEL_W = LINE_OFF_W - BYTE_W;

    typedef struct packed {
        logic                s1_live;
        logic [WSEL_W-1:0]   s1_word;
        logic [COLOUR_W-1:0] s1_colour;
        logic                out_valid;
        logic                out_hit;
        logic [WAY_W-1:0]    out_way;
        logic [WORD_W-1:0]   out_data;
        logic [COLOUR_W-1:0] out_colour;
        logic                out_alias;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [WAYS-1:0]      bank_rd_valid;
    logic [TAG_W-1:0]     bank_rd_tag  [WAYS];
    logic [LINE_BITS-1:0] bank_rd_line [WAYS];
    logic [WAYS-1:0]      fill_probe;
    logic [WAYS-1:0]      victim_oh;
    logic [WAYS-1:0]      match_vec;

    vipt_victim #(
        .WAYS  (WAYS),
        .SET_W (SET_W),
        .WAY_W (WAY_W)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (fill_valid),
        .fill_set  (fill_set),
        .set_valid (fill_probe),
        .victim_oh (victim_oh)
    );

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        vipt_way_bank #(
            .SET_W     (SET_W),
            .TAG_W     (TAG_W),
            .LINE_BITS (LINE_BITS)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (fill_valid && victim_oh[g]),
            .wr_set      (fill_set),
            .wr_tag      (fill_ppn),
            .wr_line     (fill_line),
            .rd_en       (req_valid),
            .rd_set      (req_vword[VWORD_W-1 -: SET_W]),
            .rd_valid    (bank_rd_valid[g]),
            .rd_tag      (bank_rd_tag[g]),
            .rd_line     (bank_rd_line[g]),
            .probe_set   (fill_set),
            .probe_valid (fill_probe[g])
        );

        assign match_vec[g] = pipe_q.s1_live && bank_rd_valid[g] && (bank_rd_tag[g] == xlat_ppn);
    end

    always_comb begin
        pipe_d = pipe_q;

        pipe_d.s1_live = req_valid;
        if (req_valid) begin
            pipe_d.s1_word   = req_vword[WSEL_W-1:0];
            pipe_d.s1_colour = req_vword[VWORD_W-1 -: COLOUR_W];
        end

        pipe_d.out_valid = pipe_q.s1_live;
        pipe_d.out_hit   = 1'b0;
        pipe_d.out_way   = '0;
        pipe_d.out_data  = '0;
        if (pipe_q.s1_live) begin
            pipe_d.out_colour = pipe_q.s1_colour;
            pipe_d.out_alias  = (pipe_q.s1_colour != xlat_ppn[COLOUR_W-1:0]);
            for (int w = 0; w < WAYS; w++) begin
                if (match_vec[w]) begin
                    pipe_d.out_hit  = 1'b1;
                    pipe_d.out_way  = WAY_W'(w);
                    pipe_d.out_data = bank_rd_line[w][pipe_q.s1_word * WORD_W +: WORD_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign rsp_valid  = pipe_q.out_valid;
    assign rsp_hit    = pipe_q.out_hit;
    assign rsp_way    = pipe_q.out_way;
    assign rsp_data   = pipe_q.out_data;
    assign rsp_colour = pipe_q.out_colour;
    assign rsp_alias  = pipe_q.out_alias;

endmodule

// File: rtl/vipt_cache_checker.sv
module vipt_cache_checker #(
    parameter int WAYS     = 4,
    parameter int WAY_W    = 2,
    parameter int WORD_W   = 32,
    parameter int TAG_W    = 24,
    parameter int COLOUR_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [TAG_W-1:0]    xlat_ppn,
    input logic                rsp_valid,
    input logic                rsp_hit,
    input logic [WAY_W-1:0]    rsp_way,
    input logic [WORD_W-1:0]   rsp_data,
    input logic [COLOUR_W-1:0] rsp_colour,
    input logic                rsp_alias,
    input logic [WAYS-1:0]     match_vec
);

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rsp_valid);

    assert_response_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ##2 rsp_valid);

    assert_no_orphan_response_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid, 2));

    assert_miss_zeroed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_data == '0 && rsp_way == '0));

    assert_alias_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_alias == (rsp_colour != $past(xlat_ppn[COLOUR_W-1:0]))));

    assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

endmodule

bind vipt_cache vipt_cache_checker #(
    .WAYS     (WAYS),
    .WAY_W    (WAY_W),
    .WORD_W   (WORD_W),
    .TAG_W    (TAG_W),
    .COLOUR_W (COLOUR_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .xlat_ppn   (xlat_ppn),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_way    (rsp_way),
    .rsp_data   (rsp_data),
    .rsp_colour (rsp_colour),
    .rsp_alias  (rsp_alias),
    .match_vec  (match_vec)
);

// File: tb/vipt_cache_test.sv
`timescale 1ns/1ps
module vipt_cache_test;

    localparam int NSETS = 16;
    localparam int NWAYS = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [7:0]   req_vword = '0;
    logic [23:0]  xlat_ppn = '0;
    logic         fill_valid = 1'b0;
    logic [3:0]   fill_set = '0;
    logic [23:0]  fill_ppn = '0;
    logic [511:0] fill_line = '0;
    logic         rsp_valid, rsp_hit, rsp_alias;
    logic [1:0]   rsp_way, rsp_colour;
    logic [31:0]  rsp_data;

    vipt_cache uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vword(req_vword),
        .xlat_ppn(xlat_ppn), .fill_valid(fill_valid), .fill_set(fill_set),
        .fill_ppn(fill_ppn), .fill_line(fill_line), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_data(rsp_data),
        .rsp_colour(rsp_colour), .rsp_alias(rsp_alias)
    );

    always #2 clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    bit           mval  [NSETS][NWAYS];
    logic [23:0]  mtag  [NSETS][NWAYS];
    logic [511:0] mline [NSETS][NWAYS];
    int           mrr   [NSETS];

    logic         o_valid, o_hit, o_alias, o_pulse_gone;
    logic [1:0]   o_way, o_colour;
    logic [31:0]  o_data;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] make_line(input logic [23:0] seed);
        logic [511:0] l;
        for (int i = 0; i < 16; i++) l[i*32 +: 32] = {seed[15:0], 8'(i), 8'hA5};
        return l;
    endfunction

    function automatic logic [23:0] mk_tag(input int set, input int k);
        logic [3:0] s;
        s = 4'(set);
        return {22'(k * 97 + set * 13 + 1), s[3:2]};
    endfunction

    function automatic logic [45:0] mk_va(input logic [35:0] upper, input int set, input int word);
        return {upper, 4'(set), 4'(word), 2'b00};
    endfunction

    task automatic model_fill(input int set, input logic [23:0] tag, input logic [511:0] line);
        int v;
        v = -1;
        for (int w = NWAYS - 1; w >= 0; w--) if (!mval[set][w]) v = w;
        if (v < 0) begin
            v = mrr[set];
            mrr[set] = (mrr[set] + 1) % NWAYS;
        end
        mval[set][v]  = 1;
        mtag[set][v]  = tag;
        mline[set][v] = line;
    endtask

    task automatic model_lookup(input logic [45:0] va, input logic [31:0] pa,
                                output logic h, output logic [1:0] way, output logic [31:0] data);
        int set, word;
        set  = int'(va[9:6]);
        word = int'(va[5:2]);
        h = 0; way = 0; data = 0;
        for (int w = 0; w < NWAYS; w++) begin
            if (mval[set][w] && mtag[set][w] == pa[31:8]) begin
                h = 1; way = 2'(w); data = mline[set][w][word*32 +: 32];
            end
        end
    endtask

    task automatic do_fill(input int set, input logic [23:0] tag, input logic [511:0] line);
        @(negedge clk);
        fill_valid = 1'b1; fill_set = 4'(set); fill_ppn = tag; fill_line = line;
        @(negedge clk);
        fill_valid = 1'b0;
        model_fill(set, tag, line);
    endtask

    task automatic do_lookup(input logic [45:0] va, input logic [31:0] pa);
        @(negedge clk);
        req_valid = 1'b1; req_vword = va[9:2];
        @(negedge clk);
        req_valid = 1'b0; xlat_ppn = pa[31:8];
        @(negedge clk);
        o_valid = rsp_valid; o_hit = rsp_hit; o_way = rsp_way; o_data = rsp_data;
        o_colour = rsp_colour; o_alias = rsp_alias;
        @(negedge clk);
        o_pulse_gone = !rsp_valid;
    endtask

    task automatic check_lookup(input string req, input logic [45:0] va, input logic [31:0] pa);
        logic eh; logic [1:0] ew; logic [31:0] ed;
        model_lookup(va, pa, eh, ew, ed);
        do_lookup(va, pa);
        chk({req, " valid"}, 64'(o_valid), 64'd1);
        chk({req, " hit"},   64'(o_hit), 64'(eh));
        chk({req, " way"},   64'(o_way), 64'(ew));
        chk({req, " data"},  64'(o_data), 64'(ed));
        chk({req, " colour R7"}, 64'(o_colour), 64'(va[9:8]));
        chk({req, " alias R7"},  64'(o_alias), 64'(va[9:8] != pa[9:8]));
    endtask

    initial begin
        for (int s = 0; s < NSETS; s++) begin
            mrr[s] = 0;
            for (int w = 0; w < NWAYS; w++) mval[s][w] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);

        // R1: nothing valid after reset
        check_lookup("R1 empty lookup", mk_va(36'h5, 5, 3), {mk_tag(5, 0), 8'h0C});

        // R5/R2/R4: fill four ways of set 5 in order
        for (int k = 0; k < 4; k++) do_fill(5, mk_tag(5, k), make_line(mk_tag(5, k)));
        for (int k = 0; k < 4; k++) begin
            check_lookup("R5 lowest invalid way", mk_va(36'h11, 5, k == 3 ? 15 : k), {mk_tag(5, k), 8'h00});
            chk("R5 way order", 64'(o_way), 64'(k));
            chk("R3 single pulse", 64'(o_pulse_gone), 64'd1);
        end
        chk("R4 last word", 64'(o_data), 64'({mk_tag(5, 3)[15:0], 8'd15, 8'hA5}));

        // R6: full set replaces round-robin
        do_fill(5, mk_tag(5, 10), make_line(mk_tag(5, 10)));
        check_lookup("R6 first victim", mk_va(36'h2, 5, 1), {mk_tag(5, 10), 8'h04});
        chk("R6 victim way0", 64'(o_way), 64'd0);
        check_lookup("R2 evicted tag misses", mk_va(36'h2, 5, 1), {mk_tag(5, 0), 8'h04});
        chk("R2 evicted miss", 64'(o_hit), 64'd0);
        do_fill(5, mk_tag(5, 11), make_line(mk_tag(5, 11)));
        check_lookup("R6 second victim", mk_va(36'h2, 5, 2), {mk_tag(5, 11), 8'h08});
        chk("R6 victim way1", 64'(o_way), 64'd1);

        // R6: independent pointer in set 6
        for (int k = 0; k < 5; k++) do_fill(6, mk_tag(6, k), make_line(mk_tag(6, k)));
        check_lookup("R6 per-set pointer", mk_va(36'h3, 6, 0), {mk_tag(6, 4), 8'h00});
        chk("R6 set6 way0", 64'(o_way), 64'd0);

        // R9: synonyms share colour, hit same way
        check_lookup("R9 synonym A", mk_va(36'h000001, 5, 7), {mk_tag(5, 2), 8'h1C});
        chk("R9 synonym A hit", 64'(o_hit), 64'd1);
        check_lookup("R9 synonym B", mk_va(36'hABCDE, 5, 7), {mk_tag(5, 2), 8'h1C});
        chk("R9 synonym B way", 64'(o_way), 64'd2);

        // R7: colour mismatch flagged
        check_lookup("R7 alias", mk_va(36'h7, 5, 0), {mk_tag(5, 2) ^ 24'h3, 8'h00});
        chk("R7 alias set", 64'(o_alias), 64'd1);

        // Random traffic over a few sets
        void'($urandom(32'd1234));
        for (int it = 0; it < 500; it++) begin
            int set, k, word;
            logic [23:0] tag;
            logic [45:0] va;
            logic [31:0] pa;
            logic eh; logic [1:0] ew; logic [31:0] ed;
            set  = 8 + int'($urandom % 4);
            k    = int'($urandom % 6);
            word = int'($urandom % 16);
            tag  = mk_tag(set, k);
            if ($urandom % 10 == 0) tag = tag ^ 24'(1 + $urandom % 3);
            va = mk_va(36'($urandom), set, word);
            pa = {tag, 8'($urandom)};
            check_lookup("R2 random", va, pa);
            model_lookup(va, pa, eh, ew, ed);
            if (!eh && ($urandom % 2 == 0)) do_fill(set, tag, make_line(tag));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R3 watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule